// File: doc/BRIEF.md
# Register-Programmed Serial Shift Master

This block is a small master for a four-wire serial bus of the SPI family. Software reaches it through a plain 32-bit register port with three words. A status word holds the per-device select bits, a shift-rate code and a completion flag. A command word starts a transfer and gives its direction and byte count. A data word is shifted out on a write and collects the incoming bits on a read. Up to four bytes move per command, MSB first, in clock mode 0 (clock idles low, data sampled on the rising edge).

A typical access holds a device selected and issues two commands back to back: a write carrying an address word, then a read or write carrying the payload. Software polls the completion flag between commands and clears it by writing one to it. Clearing the status word releases every chip select and closes the access.

The shift clock comes from the block clock. A parameter gives that clock in MHz, and the rate code picks a shift rate of 1, 2, 4, 8, 16 or 32 MHz.

Top module: `serbus_master`

## Requirements
- R1: Register words sit at byte offsets 0 (status), 12 (command) and 16 (data). All three read as zero after reset, and any other offset reads zero.
- R2: Status bits 9:7 are device selects. Bit 7+i set drives `ser_cs_n[i]` low, and bit 7+i clear drives it high. Writing zero to the status word releases every select.
- R3: Status bits 6:4 hold a rate code c. The shift clock period is 2*((REF_MHZ/2)>>c) block clock cycles, which is 1 MHz shifted left by c. Codes 6 and 7 behave like code 5.
- R4: Status bit 3 is set in the cycle a transfer ends. Writing 1 to bit 3 clears it, and writing 0 to bit 3 leaves it unchanged.
- R5: A command word starts a transfer only when bit 0 is 1, bit 1 (mode) is 0 and bits 3:2 are 0 (read) or 1 (write). Bits 5:4 hold the byte count minus one. Any other command does nothing. Command bit 0 reads 1 while a transfer runs and 0 otherwise.
- R6: While a transfer runs, writes to the command word and to the data word are ignored.
- R7: A transfer of k bytes gives exactly 8k shift clock pulses. The clock is low whenever no transfer runs.
- R8: On a write, `ser_mosi` carries the data word MSB first. Afterwards the data word equals the original value shifted left by 8k bits with zero fill.
- R9: On a read, `ser_mosi` stays low and `ser_miso` is sampled on rising clock edges. Afterwards the data word equals (original << 8k) with the 8k received bits, first bit highest, in its low bits.
- R10: Chip selects do not change when a transfer ends, so back-to-back transfers to one device stay inside one select window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock and shift-rate reference |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| ser_clk | output | 1 | Shift clock, idle low |
| ser_mosi | output | 1 | Serial data to devices |
| ser_miso | input | 1 | Serial data from devices |
| ser_cs_n | output | 3 | Active-low chip selects, one per device |

## Verification
The hardest case to reach is a command or data write that lands while a shift is in progress. A register port write finishes in one cycle, so the gap only opens when a slow rate code stretches a one-byte transfer over many cycles. The bench starts such a slow transfer, then writes a four-byte command and an all-ones data word at once. It checks that only eight pulses appear and that the data word holds the first payload shifted by one byte. Select continuity across two back-to-back transfers is watched on every cycle, and the rate codes above the table's end are driven directly.

// File: rtl/serbus_pkg.sv
package serbus_pkg;
   localparam logic [4:0] OFS_STAT = 5'd0;
   localparam logic [4:0] OFS_CMD  = 5'd12;
   localparam logic [4:0] OFS_DATA = 5'd16;

   localparam int STAT_DONE_BIT = 3;
   localparam int STAT_RATE_LSB = 4;
   localparam int STAT_DEV_LSB  = 7;
   localparam int RATE_W        = 3;
   localparam int RATE_TOP      = 5;

   localparam int CMD_GO_BIT   = 0;
   localparam int CMD_MODE_BIT = 1;
   localparam int CMD_DIR_LSB  = 2;
   localparam int CMD_LEN_LSB  = 4;
   localparam int LEN_W        = 2;

   typedef enum logic [1:0] {
      DIR_RD  = 2'd0,
      DIR_WR  = 2'd1,
      DIR_RS2 = 2'd2,
      DIR_RS3 = 2'd3
   } dir_e;
endpackage

// File: rtl/serbus_rate_gen.sv
module serbus_rate_gen #(
   parameter int REF_MHZ  = 64,
   parameter int CODE_W   = 3,
   parameter int MAX_CODE = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              run,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);
   localparam int HALF0 = REF_MHZ / 2;
   localparam int CNT_W = $clog2(HALF0 + 1);

   logic [CODE_W-1:0] eff_code;
   logic [CNT_W-1:0]  half_len;
   logic [CNT_W-1:0]  cnt_q;
   logic              at_end;

   always_comb begin
      eff_code = (code > CODE_W'(MAX_CODE)) ? CODE_W'(MAX_CODE) : code;
      half_len = CNT_W'(HALF0 >> eff_code);
      at_end   = (cnt_q == half_len - 1'b1);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           cnt_q <= '0;
      else if (!run)        cnt_q <= '0;
      else if (at_end)      cnt_q <= '0;
      else                  cnt_q <= cnt_q + 1'b1;
   end

   assign tick = run && at_end;
endmodule

// File: rtl/serbus_shifter.sv
module serbus_shifter #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              is_write,
   input  logic [LEN_W-1:0]  len_m1,
   input  logic              load,
   input  logic [DATA_W-1:0] load_val,
   input  logic              miso,
   input  logic              tick,
   output logic              busy,
   output logic              sclk,
   output logic              mosi,
   output logic [DATA_W-1:0] data,
   output logic              done
);
   localparam int BCNT_W = $clog2(DATA_W + 1);

   logic              busy_q, sclk_q, wr_q, samp_q;
   logic [BCNT_W-1:0] bits_q, last_q;
   logic [DATA_W-1:0] data_q;
   logic              at_last;

   assign at_last = (bits_q == last_q);
   assign done    = busy_q && tick && sclk_q && at_last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         sclk_q <= 1'b0;
         wr_q   <= 1'b0;
         samp_q <= 1'b0;
         bits_q <= '0;
         last_q <= '0;
         data_q <= '0;
      end else if (!busy_q) begin
         sclk_q <= 1'b0;
         if (start) begin
            busy_q <= 1'b1;
            wr_q   <= is_write;
            bits_q <= '0;
            last_q <= BCNT_W'({len_m1, 3'b111});
         end else if (load) begin
            data_q <= load_val;
         end
      end else if (tick) begin
         if (!sclk_q) begin
            sclk_q <= 1'b1;
            samp_q <= wr_q ? 1'b0 : miso;
         end else begin
            sclk_q <= 1'b0;
            data_q <= {data_q[DATA_W-2:0], samp_q};
            if (at_last) busy_q <= 1'b0;
            else         bits_q <= bits_q + 1'b1;
         end
      end
   end

   assign busy = busy_q;
   assign sclk = sclk_q;
   assign mosi = busy_q && wr_q && data_q[DATA_W-1];
   assign data = data_q;
endmodule

// File: rtl/serbus_master.sv
module serbus_master
   import serbus_pkg::*;
#(
   parameter int REF_MHZ = 64,
   parameter int N_DEV   = 3,
   parameter int DATA_W  = 32,
   parameter int ADDR_W  = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              ser_clk,
   output logic              ser_mosi,
   input  logic              ser_miso,
   output logic [N_DEV-1:0]  ser_cs_n
);
   if (REF_MHZ < 64 || (REF_MHZ % 64) != 0)
      $error("REF_MHZ must be a positive multiple of 64");
   if (N_DEV < 1 || N_DEV > 3)
      $error("N_DEV must lie in 1..3 to fit the select field");
   if (DATA_W != 32)
      $error("DATA_W must be 32");
   if (ADDR_W != 5)
      $error("ADDR_W must be 5");

   logic             wr_stat, wr_cmd, wr_data, start_ok;
   logic [N_DEV-1:0] dev_q;
   logic [RATE_W-1:0] rate_q;
   logic             done_q;
   logic             cmd_mode_q;
   dir_e             cmd_dir_q;
   logic [LEN_W-1:0] cmd_len_q;
   logic             xfer_busy, xfer_done, tick, xfer_is_wr;
   logic [DATA_W-1:0] xfer_data;
   dir_e             new_dir;

   assign wr_stat = reg_wr && (reg_addr == OFS_STAT);
   assign wr_cmd  = reg_wr && (reg_addr == OFS_CMD);
   assign wr_data = reg_wr && (reg_addr == OFS_DATA);
   assign new_dir = dir_e'(reg_wdata[CMD_DIR_LSB +: 2]);
   assign start_ok = wr_cmd && !xfer_busy && reg_wdata[CMD_GO_BIT]
                     && !reg_wdata[CMD_MODE_BIT]
                     && (new_dir == DIR_RD || new_dir == DIR_WR);
   assign xfer_is_wr = (cmd_dir_q == DIR_WR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dev_q      <= '0;
         rate_q     <= '0;
         done_q     <= 1'b0;
         cmd_mode_q <= 1'b0;
         cmd_dir_q  <= DIR_RD;
         cmd_len_q  <= '0;
      end else begin
         if (wr_stat) begin
            dev_q  <= reg_wdata[STAT_DEV_LSB +: N_DEV];
            rate_q <= reg_wdata[STAT_RATE_LSB +: RATE_W];
         end
         if (xfer_done)
            done_q <= 1'b1;
         else if (wr_stat && reg_wdata[STAT_DONE_BIT])
            done_q <= 1'b0;
         if (start_ok) begin
            cmd_mode_q <= reg_wdata[CMD_MODE_BIT];
            cmd_dir_q  <= new_dir;
            cmd_len_q  <= reg_wdata[CMD_LEN_LSB +: LEN_W];
         end
      end
   end

   serbus_rate_gen #(
      .REF_MHZ (REF_MHZ),
      .CODE_W  (RATE_W),
      .MAX_CODE(RATE_TOP)
   ) u_rate (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (xfer_busy),
      .code (rate_q),
      .tick (tick)
   );

   serbus_shifter #(
      .DATA_W(DATA_W),
      .LEN_W (LEN_W)
   ) u_shift (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start_ok),
      .is_write(new_dir == DIR_WR),
      .len_m1  (reg_wdata[CMD_LEN_LSB +: LEN_W]),
      .load    (wr_data),
      .load_val(reg_wdata),
      .miso    (ser_miso),
      .tick    (tick),
      .busy    (xfer_busy),
      .sclk    (ser_clk),
      .mosi    (ser_mosi),
      .data    (xfer_data),
      .done    (xfer_done)
   );

   for (genvar gi = 0; gi < N_DEV; gi++) begin : g_cs
      assign ser_cs_n[gi] = ~dev_q[gi];
   end

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         OFS_STAT: begin
            reg_rdata[STAT_DEV_LSB +: N_DEV]   = dev_q;
            reg_rdata[STAT_RATE_LSB +: RATE_W] = rate_q;
            reg_rdata[STAT_DONE_BIT]           = done_q;
         end
         OFS_CMD: begin
            reg_rdata[CMD_GO_BIT]             = xfer_busy;
            reg_rdata[CMD_MODE_BIT]           = cmd_mode_q;
            reg_rdata[CMD_DIR_LSB +: 2]       = cmd_dir_q;
            reg_rdata[CMD_LEN_LSB +: LEN_W]   = cmd_len_q;
         end
         OFS_DATA: reg_rdata = xfer_data;
         default:  reg_rdata = '0;
      endcase
   end
endmodule

// File: rtl/serbus_master_chk.sv
module serbus_master_chk #(
   parameter int N_DEV = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             busy,
   input logic             sclk,
   input logic             mosi,
   input logic             is_wr,
   input logic             done_flag,
   input logic             stat_wr,
   input logic [N_DEV-1:0] cs_n,
   input logic [1:0]       len
);
   AST_CLK_ONLY_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> busy);                                               // R7
   AST_XFER_STARTS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !sclk);                                       // R7
   AST_END_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done_flag);                                   // R4
   AST_READ_MOSI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !is_wr) |-> !mosi);                                  // R9
   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(stat_wr) |-> $stable(cs_n));                           // R10
   AST_LEN_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(len));                                       // R6
endmodule

bind serbus_master serbus_master_chk #(.N_DEV(N_DEV)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (xfer_busy),
   .sclk     (ser_clk),
   .mosi     (ser_mosi),
   .is_wr    (xfer_is_wr),
   .done_flag(done_q),
   .stat_wr  (wr_stat),
   .cs_n     (ser_cs_n),
   .len      (cmd_len_q)
);

// File: tb/serbus_master_test.sv
module serbus_master_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        ser_clk, ser_mosi;
   logic [2:0]  ser_cs_n;
   logic [31:0] sl_tx = '0;
   logic [31:0] sl_rx = '0;
   int          pulses = 0;
   int          n_chk = 0;
   int          n_fail = 0;
   bit          finished = 0;
   bit          cs_watch = 0;
   int          cs_drops = 0;

   always #4 clk = ~clk;

   serbus_master uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ser_clk(ser_clk),
      .ser_mosi(ser_mosi), .ser_miso(sl_tx[31]), .ser_cs_n(ser_cs_n)
   );

   always @(posedge ser_clk) begin
      sl_rx  = {sl_rx[30:0], ser_mosi};
      pulses = pulses + 1;
   end
   always @(negedge ser_clk) sl_tx = sl_tx << 1;
   always @(negedge clk) if (cs_watch && ser_cs_n[1]) cs_drops++;

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic wait_done();
      logic [31:0] s;
      for (int i = 0; i < 20000; i++) begin
         rd(5'd0, s);
         if (s[3]) return;
      end
      check("R4 done timeout", 32'd0, 32'd1);
   endtask

   function automatic logic [31:0] exp_after(input logic [31:0] orig, input logic [31:0] sl,
                                             input int k, input bit is_wr);
      logic [63:0] t;
      t = {32'd0, orig} << (8 * k);
      if (!is_wr) t = t | ({32'd0, sl} >> (32 - 8 * k));
      return t[31:0];
   endfunction

   function automatic int half_of(input int c);
      return 32 >> ((c > 5) ? 5 : c);
   endfunction

   task automatic xfer(input bit is_wr, input int k, input int rate,
                       input logic [31:0] d, input logic [31:0] sl);
      logic [31:0] r;
      wr(5'd0, 32'h100 | (rate << 4) | 32'h8);
      wr(5'd16, d);
      sl_tx = sl; sl_rx = 0; pulses = 0;
      wr(5'd12, ((k - 1) << 4) | (is_wr ? 32'h4 : 32'h0) | 32'h1);
      wait_done();
      @(negedge clk);
      check("R7 pulse count", pulses, 8 * k);
      if (is_wr) check("R8 mosi bits", sl_rx, d >> (32 - 8 * k));
      else       check("R9 mosi low on read", sl_rx, 32'd0);
      rd(5'd16, r);
      check(is_wr ? "R8 data after write" : "R9 data after read", r, exp_after(d, sl, k, is_wr));
   endtask

   initial begin
      logic [31:0] r, d, s;
      int per, hi;
      void'($urandom(32'h5EED_0042));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      rd(5'd0, r);  check("R1 status reset", r, 0);
      rd(5'd12, r); check("R1 command reset", r, 0);
      rd(5'd16, r); check("R1 data reset", r, 0);
      rd(5'd8, r);  check("R1 unmapped offset", r, 0);
      check("R2 cs reset", ser_cs_n, 3'b111);
      check("R7 clock idle", ser_clk, 0);

      wr(5'd0, 32'h080); check("R2 dev0 select", ser_cs_n, 3'b110);
      wr(5'd0, 32'h200); check("R2 dev2 select", ser_cs_n, 3'b011);
      wr(5'd0, 32'h0);   check("R2 zero deselects", ser_cs_n, 3'b111);

      xfer(1, 4, 5, 32'hA5C3_0F96, 32'h0);
      rd(5'd0, r);  check("R4 flag set", r[3], 1);
      rd(5'd12, r); check("R5 start bit clear after", r[0], 0);
      check("R10 cs held after end", ser_cs_n[1], 0);
      wr(5'd0, 32'h150);
      rd(5'd0, r);  check("R4 write 0 keeps flag", r[3], 1);
      wr(5'd0, 32'h158);
      rd(5'd0, r);  check("R4 write 1 clears flag", r[3], 0);

      xfer(0, 2, 5, 32'h1234_5678, 32'hBEEF_0123);

      // R6: writes during a slow one-byte transfer are dropped
      wr(5'd0, 32'h138);
      d = 32'h3C00_00A7;
      wr(5'd16, d);
      sl_tx = 0; sl_rx = 0; pulses = 0;
      wr(5'd12, 32'h05);
      rd(5'd12, r); check("R5 start bit reads busy", r[0], 1);
      wr(5'd12, 32'h35);
      wr(5'd16, 32'hFFFF_FFFF);
      wait_done();
      @(negedge clk);
      check("R6 command ignored while busy", pulses, 8);
      rd(5'd16, r); check("R6 data write ignored while busy", r, d << 8);

      // R5: rejected commands
      wr(5'd0, 32'h158); pulses = 0;
      wr(5'd12, 32'h03);
      rd(5'd12, r); check("R5 mode bit rejects", r[0], 0);
      wr(5'd12, 32'h09);
      rd(5'd12, r); check("R5 dir 2 rejects", r[0], 0);
      wr(5'd12, 32'h04);
      repeat (20) @(negedge clk);
      check("R5 no pulses for rejected", pulses, 0);

      // R3: rate codes including 6 and 7
      for (int c = 0; c < 8; c++) begin
         wr(5'd0, 32'h108 | (c << 4));
         wr(5'd12, 32'h05);
         hi = 0; per = 0;
         while (!ser_clk) @(negedge clk);
         while (ser_clk) begin @(negedge clk); per++; end
         while (!ser_clk) begin @(negedge clk); per++; end
         check($sformatf("R3 period code %0d", c), per, 2 * half_of(c));
         wait_done();
      end

      // R10: two back-to-back transfers inside one select window
      wr(5'd0, 32'h158);
      cs_watch = 1;
      xfer(1, 4, 5, 32'h8000_1F00, 32'h0);
      xfer(0, 4, 5, 32'h0, 32'hC001_D00D);
      cs_watch = 0;
      check("R10 cs continuous", cs_drops, 0);

      for (int it = 0; it < 24; it++) begin
         d = $urandom; s = $urandom;
         xfer(1'($urandom % 2), int'($urandom % 4) + 1, int'($urandom % 3) + 3, d, s);
      end

      wr(5'd0, 32'h0);
      check("R2 final deselect", ser_cs_n, 3'b111);

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finish");
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   end
endmodule